// File: doc/BRIEF.md
# Misaligned Load Data Aligner

This unit sits on the load return path of a 32-bit CPU, between the memory read data and the register file write port. It takes the aligned 32-bit word that contains the load address, the two low address bits and the load kind, and produces the value written to the destination register. Misaligned word and unsigned halfword loads do not fault. Instead the extracted data is rotated right by whole bytes. A signed halfword load at an odd address becomes a sign-extended byte load of the byte at that exact address.

The data path is combinational. A parameter adds one output register stage so the unit can close timing in front of the register file write. In the default configuration the result and its valid flag appear one clock after the request. When no request is presented, the registered result holds its last value.

Top module: `ldr_align_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `result_o` are zero.
- R2: With `REG_OUT`=1 (the default), `valid_o` equals `valid_i` delayed by one clock. `result_o` carries the result of the request made in the previous cycle.
- R3: Load kind encoding: `kind_i`=2'b00 word, 2'b01 unsigned halfword, 2'b10 signed halfword, 2'b11 unsigned byte. Byte lane n of `data_i` is bits 8n+7:8n. A word load returns `data_i` rotated right by 8·`addr_i`.
- R4: A word load at `addr_i`=0 returns `data_i` unchanged, with no shift by the full width.
- R5: An unsigned halfword load uses the halfword selected by `addr_i[1]` (0 = bits 15:0, 1 = bits 31:16). At an even address that halfword is zero-extended.
- R6: An unsigned halfword load at an odd address returns the zero-extended halfword rotated right by 8. The low byte lands in bits 31:24, the high byte in bits 7:0, and bits 23:8 are zero.
- R7: A signed halfword load at an even address returns the selected halfword sign-extended from its bit 15.
- R8: A signed halfword load at an odd address returns the byte in lane `addr_i`, sign-extended from its bit 7.
- R9: An unsigned byte load returns the byte in lane `addr_i`, zero-extended.
- R10: With `REG_OUT`=1, a cycle with `valid_i` low leaves `result_o` unchanged and drives `valid_o` low the next cycle, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load data present this cycle |
| kind_i | input | 2 | Load kind (see R3) |
| addr_i | input | 2 | Low address bits of the load |
| data_i | input | 32 | Aligned memory word containing the address |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Value for the destination register |

## Verification
A wrong lane select or rotate amount shows on the very next result as bytes in the wrong positions. The offsets are the ones that expose it: odd halfword offsets and word offsets 1 to 3. A wrong extension choice shows as high bits that disagree with the sign bit of the chosen byte or halfword, and patterns with both signs catch it in the same cycle. A stuck or leaking output register shows as a missing, extra or changed result one clock after the bad request. That includes a change in `result_o` across idle cycles.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    LD_WORD  = 2'b00,
    LD_UHALF = 2'b01,
    LD_SHALF = 2'b10,
    LD_UBYTE = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/ldr_lane_pick.sv
module ldr_lane_pick #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]   word_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [2*LANE_W-1:0] half_o,
  output logic [LANE_W-1:0]   byte_o
);
  localparam int unsigned HALVES = LANES / 2;

  logic [LANE_W-1:0]   lane   [LANES];
  logic [2*LANE_W-1:0] halves [HALVES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane[l] = word_i[l*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halves[h] = word_i[h*2*LANE_W +: 2*LANE_W];
  end

  assign byte_o = lane[off_i];
  assign half_o = halves[off_i[OFF_W-1:1]];
endmodule

// File: rtl/ldr_rotr.sv
module ldr_rotr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP_W = 8,
  localparam int unsigned STEPS = DATA_W / STEP_W,
  localparam int unsigned AMT_W = $clog2(STEPS)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rot [STEPS];

  for (genvar k = 0; k < STEPS; k++) begin : g_rot
    if (k == 0) begin : g_pass
      // zero amount is a straight wire, never a full-width shift
      assign rot[k] = data_i;
    end else begin : g_turn
      assign rot[k] = {data_i[k*STEP_W-1:0], data_i[DATA_W-1:k*STEP_W]};
    end
  end

  assign data_o = rot[amt_i];
endmodule

// File: rtl/ldr_extend.sv
module ldr_extend #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] half_i,
  input  logic [LANE_W-1:0]   byte_i,
  input  logic                sign_i,
  input  logic                use_byte_i,
  output logic [DATA_W-1:0]   ext_o
);
  logic [DATA_W-1:0] half_ext, byte_ext;

  assign half_ext = {{(DATA_W-2*LANE_W){sign_i & half_i[2*LANE_W-1]}}, half_i};
  assign byte_ext = {{(DATA_W-LANE_W){sign_i & byte_i[LANE_W-1]}}, byte_i};
  assign ext_o    = use_byte_i ? byte_ext : half_ext;
endmodule

// File: rtl/ldr_align_unit.sv
module ldr_align_unit #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DATA_W / ldr_pkg::LANE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  import ldr_pkg::*;

  ld_kind_e          kind;
  logic [2*LANE_W-1:0] half;
  logic [LANE_W-1:0]   byte_sel;
  logic [DATA_W-1:0]   rot_in, rot_out, ext_val, res_d;
  logic [ADDR_W-1:0]   rot_amt;
  logic                is_word;

  assign kind    = ld_kind_e'(kind_i);
  assign is_word = (kind == LD_WORD);

  ldr_lane_pick #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pick (
    .word_i (data_i),
    .off_i  (addr_i),
    .half_o (half),
    .byte_o (byte_sel)
  );

  // unsigned halfword rotates only by its own odd byte
  assign rot_in  = is_word ? data_i : {{(DATA_W-2*LANE_W){1'b0}}, half};
  assign rot_amt = is_word ? addr_i : {{(ADDR_W-1){1'b0}}, addr_i[0]};

  ldr_rotr #(.DATA_W(DATA_W), .STEP_W(LANE_W)) u_rot (
    .data_i (rot_in),
    .amt_i  (rot_amt),
    .data_o (rot_out)
  );

  ldr_extend #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ext (
    .half_i     (half),
    .byte_i     (byte_sel),
    .sign_i     (kind == LD_SHALF),
    .use_byte_i ((kind == LD_UBYTE) | addr_i[0]),
    .ext_o      (ext_val)
  );

  always_comb begin
    unique case (kind)
      LD_WORD, LD_UHALF: res_d = rot_out;
      default:           res_d = ext_val;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o  <= 1'b0;
        result_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) result_o <= res_d;
      end
    end
  end else begin : g_comb
    assign valid_o  = valid_i;
    assign result_o = res_d;
  end
endmodule

// File: rtl/ldr_align_unit_chk.sv
module ldr_align_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DATA_W / ldr_pkg::LANE_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        kind_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  import ldr_pkg::*;

  if (REG_OUT) begin : g_seq
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        assert_reset_clear_R1: assert (!valid_o && result_o == '0);
      end
    end

    assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(result_o)));

    assert_word_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_WORD && addr_i == '0) |=> result_o == $past(data_i));

    assert_uhalf_even_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_UHALF && !addr_i[0]) |=> result_o[DATA_W-1:2*LANE_W] == '0);

    assert_uhalf_odd_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_UHALF && addr_i[0]) |=> result_o[DATA_W-LANE_W-1:LANE_W] == '0);

    assert_shalf_even_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_SHALF && !addr_i[0]) |=>
        ($countones(result_o[DATA_W-1:2*LANE_W-1]) == 0 ||
         $countones(result_o[DATA_W-1:2*LANE_W-1]) == DATA_W-2*LANE_W+1));

    assert_shalf_odd_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_SHALF && addr_i[0]) |=>
        ($countones(result_o[DATA_W-1:LANE_W-1]) == 0 ||
         $countones(result_o[DATA_W-1:LANE_W-1]) == DATA_W-LANE_W+1));

    assert_ubyte_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && kind_i == LD_UBYTE) |=> result_o[DATA_W-1:LANE_W] == '0);
  end else begin : g_comb
    always_comb begin
      assert_pass_valid_R2: assert (valid_o == valid_i);
    end
  end
endmodule

bind ldr_align_unit ldr_align_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .kind_i   (kind_i),
  .addr_i   (addr_i),
  .data_i   (data_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/ldr_align_unit_test.sv
module ldr_align_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [1:0]  addr_i = 2'b00;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk_i = ~clk_i;

  ldr_align_unit uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .kind_i   (kind_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_load(logic [1:0] k, logic [1:0] a, logic [31:0] w);
    logic [63:0] dbl;
    logic [15:0] h;
    logic [7:0]  b;
    h = a[1] ? w[31:16] : w[15:0];
    b = w[8*int'(a) +: 8];
    case (k)
      2'b00: begin dbl = {w, w} >> (8*int'(a)); return dbl[31:0]; end
      2'b01: begin dbl = {16'h0, h, 16'h0, h} >> (8*int'(a[0])); return dbl[31:0]; end
      2'b10: return a[0] ? {{24{b[7]}}, b} : {{16{h[15]}}, h};
      default: return {24'h0, b};
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] k, logic [1:0] a);
    case (k)
      2'b00: return (a == 2'd0) ? "R4 word aligned" : "R3 word rotate";
      2'b01: return a[0] ? "R6 uhalf odd" : "R5 uhalf even";
      2'b10: return a[0] ? "R8 shalf odd" : "R7 shalf even";
      default: return "R9 ubyte";
    endcase
  endfunction

  task automatic drive(logic [1:0] k, logic [1:0] a, logic [31:0] w);
    @(negedge clk_i);
    valid_i = 1'b1;
    kind_i  = k;
    addr_i  = a;
    data_i  = w;
    exp_q.push_back(ref_load(k, a, w));
    tag_q.push_back(tag_of(k, a));
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R2 unexpected valid_o actual=%h expected=none", result_o);
      end else begin
        check(tag_q.pop_front(), result_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] held;
    pats[0] = 32'hF1E2D3C4;
    pats[1] = 32'h0A7B1C6D;
    pats[2] = 32'h80FF7F01;
    pats[3] = 32'h12345678;

    repeat (3) @(posedge clk_i);
    #2;
    check("R1 reset valid_o", {31'h0, valid_o}, 32'h0);
    check("R1 reset result_o", result_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 4; a++) begin
          drive(2'(k), 2'(a), pats[p]);
        end
      end
    end

    // R10: idle cycles with changing inputs must not disturb the result
    drive(2'b10, 2'd3, 32'h80FF7F01);
    idle();
    @(posedge clk_i);
    #2;
    held = result_o;
    check("R10 held equals last result", held, 32'hFFFFFF80);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      kind_i = 2'(i);
      addr_i = 2'(i + 1);
      data_i = 32'hDEAD0000 + 32'(i);
      @(posedge clk_i);
      #2;
      check("R10 valid_o low while idle", {31'h0, valid_o}, 32'h0);
      check("R10 result_o held", result_o, held);
    end

    // R2: back-to-back then one idle gap
    drive(2'b00, 2'd1, 32'hAABBCCDD);
    drive(2'b01, 2'd3, 32'hAABBCCDD);
    idle();
    drive(2'b11, 2'd2, 32'hAABBCCDD);
    idle();
    repeat (3) @(posedge clk_i);
    #3;
    check("R2 all results delivered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule